// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one DMA channel that moves 32-bit words between a device-side stream and a simple request/acknowledge memory bus. Software programs an active buffer as a pair of addresses (a running address and an end address) and may queue a second buffer in a second pair (a queued base and a queued end). When the active buffer runs out, the queued pair is copied into the active pair and the transfer carries on without a software round trip. Software can ask for a one-shot transfer instead, in which case the channel halts at the end of the active buffer.

A single control/status word starts, stops and clears the channel. Writes to it carry independent set and clear strobes, so one write can, for example, wipe the flags and re-enable the channel. Reads return the run, one-shot, done and bus-fault flags. An interrupt line stays high while either the done flag or the bus-fault flag is set. Whenever the channel halts, it takes a snapshot of all four address registers so that software can resume after an error. Address writes that are not on a 16-byte boundary are rejected.

Top module: `dma_chain_channel`

## Requirements
- R1: The active buffer ends when the running address equals the end address and no word is held in the staging register. The channel never reads memory at or beyond the end address and never accepts a device word there, so exactly (end - running)/4 words move per buffer.
- R2: Each memory access that is acknowledged without error advances the running address by 4. Device-to-memory mode writes each accepted device word at the running address. Memory-to-device mode delivers each word read from the running address on the device output, in address order.
- R3: If the active buffer ends while one-shot mode is clear and the done flag is clear, the queued base and queued end are copied into the running and end addresses, the done flag is set, and the run flag stays set.
- R4: If the active buffer ends while one-shot mode is set, the done flag is set, the run flag is cleared and the channel stops.
- R5: If the active buffer ends while the done flag is already set, the channel stops (the run flag is cleared) instead of chaining, which leaves the running address at the end address.
- R6: An error response on the memory bus sets the bus-fault flag and clears the run flag. The running address stays on the faulting word and no further memory request is made.
- R7: Register addresses are 0 for control/status, 1 for the running address, 2 for the end address, 3 for the queued base, 4 for the queued end, and 5 to 8 for the snapshots of these four in the same order. All registers read 0 after reset. The control/status read view shows the run flag at bit 24, one-shot at bit 25, done at bit 27 and bus-fault at bit 28, with all other bits 0.
- R8: The control/status write view uses these bits: bit 16 sets run, bit 17 sets one-shot, bit 18 selects the direction (1 = device to memory, 0 = memory to device, taken on every such write), bit 19 clears done, bit 20 is the wipe strobe and bit 21 flushes the staging register. When a write carries both clear and set strobes, the sets take effect.
- R9: The wipe strobe clears the run, one-shot, done and bus-fault flags in one write.
- R10: The interrupt output is high exactly while done or bus-fault is set. A clear-done write drops it when no bus fault is pending.
- R11: A write to any of the four address registers whose low 4 data bits are not all zero is ignored, and the register keeps its previous value.
- R12: Whenever the channel halts (by R4, R5 or R6), the snapshot registers capture the running, end, queued base and queued end addresses as they stand at that moment.
- R13: A flush write discards a word held in the staging register, so the next transfer begins with a fresh device word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register address (read and write) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| dev_in_valid | input | 1 | Device word offered (device-to-memory) |
| dev_in_ready | output | 1 | Channel accepts the device word |
| dev_in_data | input | 32 | Device word |
| dev_out_valid | output | 1 | Word offered to the device (memory-to-device) |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_out_data | output | 32 | Word to the device |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed (bus error) |
| irq | output | 1 | Interrupt, high while done or bus-fault is set |

## Verification
The hardest state to reach from the ports is a word stranded in the staging register. It only arises when a bus error hits a device-to-memory write after the device word has been accepted, and it is invisible to register reads. The bench injects an error at a chosen address. It keeps the direction bit at device-to-memory through the following wipe and flush writes, because the stranded word would otherwise leak out on the device output. It then starts a new one-shot buffer and checks that the first word written to memory is a fresh device word. The chaining moment is caught by polling the running address every cycle and reading the flags in the same low clock phase it switches to the queued base.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int WORD_BYTES = 4;

    // read view of the control/status word
    localparam int RD_RUN_BIT    = 24;
    localparam int RD_ONCE_BIT   = 25;
    localparam int RD_DONE_BIT   = 27;
    localparam int RD_FAULT_BIT  = 28;

    // write view of the control/status word
    localparam int WR_SET_RUN    = 16;
    localparam int WR_SET_ONCE   = 17;
    localparam int WR_TO_MEM     = 18;
    localparam int WR_CLR_DONE   = 19;
    localparam int WR_WIPE       = 20;
    localparam int WR_FLUSH      = 21;

    typedef enum logic [3:0] {
        REG_CSR      = 4'd0,
        REG_RUN_ADR  = 4'd1,
        REG_END_ADR  = 4'd2,
        REG_Q_BASE   = 4'd3,
        REG_Q_END    = 4'd4,
        REG_SV_RUN   = 4'd5,
        REG_SV_END   = 4'd6,
        REG_SV_QBASE = 4'd7,
        REG_SV_QEND  = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic set_run;
        logic set_once;
        logic to_mem;
        logic clr_done;
        logic wipe;
        logic flush;
    } csr_cmd_t;

    typedef struct packed {
        logic run;
        logic once;
        logic done;
        logic fault;
    } chan_flags_t;

    function automatic csr_cmd_t decode_cmd(input logic [31:0] w);
        csr_cmd_t c;
        c.set_run  = w[WR_SET_RUN];
        c.set_once = w[WR_SET_ONCE];
        c.to_mem   = w[WR_TO_MEM];
        c.clr_done = w[WR_CLR_DONE];
        c.wipe     = w[WR_WIPE];
        c.flush    = w[WR_FLUSH];
        return c;
    endfunction

    function automatic logic [31:0] flags_word(input chan_flags_t f);
        logic [31:0] w;
        w = '0;
        w[RD_RUN_BIT]   = f.run;
        w[RD_ONCE_BIT]  = f.once;
        w[RD_DONE_BIT]  = f.done;
        w[RD_FAULT_BIT] = f.fault;
        return w;
    endfunction

endpackage

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        csr_wr,
    input  csr_cmd_t    cmd,
    input  logic        buf_end,
    input  logic        bus_fault,
    output chan_flags_t flags,
    output logic        to_mem,
    output logic        chain,
    output logic        halt,
    output logic        flush
);

    assign chain = buf_end && !flags.once && !flags.done;
    assign halt  = (buf_end && (flags.once || flags.done)) || bus_fault;
    assign flush = csr_wr && cmd.flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            to_mem <= 1'b0;
        end else begin
            if (buf_end) begin
                flags.done <= 1'b1;
                if (flags.once || flags.done)
                    flags.run <= 1'b0;
            end
            if (bus_fault) begin
                flags.fault <= 1'b1;
                flags.run   <= 1'b0;
            end
            if (csr_wr) begin
                to_mem <= cmd.to_mem;
                if (cmd.clr_done) flags.done <= 1'b0;
                if (cmd.wipe)     flags      <= '0;
                if (cmd.set_run)  flags.run  <= 1'b1;
                if (cmd.set_once) flags.once <= 1'b1;
            end
        end
    end

    assert_once_stop_R4: assert property (@(posedge clk) disable iff (rst)
        buf_end && flags.once && !csr_wr |=> !flags.run && flags.done);

    assert_overrun_stop_R5: assert property (@(posedge clk) disable iff (rst)
        buf_end && flags.done && !csr_wr |=> !flags.run);

    assert_chain_keeps_run_R3: assert property (@(posedge clk) disable iff (rst)
        chain && !csr_wr |=> flags.run && flags.done);

    assert_fault_stop_R6: assert property (@(posedge clk) disable iff (rst)
        bus_fault && !csr_wr |=> flags.fault && !flags.run);

    assert_wipe_clears_R9: assert property (@(posedge clk) disable iff (rst)
        csr_wr && cmd.wipe && !cmd.set_run && !cmd.set_once |=> flags == '0);

endmodule

// File: rtl/dma_chain_ptrs.sv
module dma_chain_ptrs
    import dma_chain_pkg::*;
#(
    parameter int AW         = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             wr_sel,
    input  logic [AW-1:0]        wr_data,
    input  logic                 advance,
    input  logic                 chain,
    input  logic                 snap,
    output logic [AW-1:0]        run_adr,
    output logic [AW-1:0]        end_adr,
    output logic [AW-1:0]        q_base,
    output logic [AW-1:0]        q_end,
    output logic [3:0][AW-1:0]   saved,
    output logic                 at_end
);

    localparam int             NPTR = 4;
    localparam logic [AW-1:0]  STEP = AW'(WORD_BYTES);

    logic aligned;
    logic [AW-1:0] live [NPTR];

    assign aligned = (wr_data[ALIGN_BITS-1:0] == '0);
    assign at_end  = (run_adr == end_adr);

    assign live[0] = run_adr;
    assign live[1] = end_adr;
    assign live[2] = q_base;
    assign live[3] = q_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_adr <= '0;
            end_adr <= '0;
            q_base  <= '0;
            q_end   <= '0;
        end else begin
            if (advance) run_adr <= run_adr + STEP;
            if (chain) begin
                run_adr <= q_base;
                end_adr <= q_end;
            end
            if (wr_en && aligned) begin
                case (wr_sel)
                    REG_RUN_ADR: run_adr <= wr_data;
                    REG_END_ADR: end_adr <= wr_data;
                    REG_Q_BASE:  q_base  <= wr_data;
                    REG_Q_END:   q_end   <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_snap
        always_ff @(posedge clk) begin
            if (rst)       saved[g] <= '0;
            else if (snap) saved[g] <= live[g];
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        advance && !chain && !(wr_en && wr_sel == REG_RUN_ADR)
        |=> run_adr == $past(run_adr) + STEP);

    assert_chain_load_R3: assert property (@(posedge clk) disable iff (rst)
        chain && !wr_en |=> run_adr == $past(q_base) && end_adr == $past(q_end));

    assert_misaligned_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en && !aligned && wr_sel == REG_Q_BASE |=> $stable(q_base));

    assert_snapshot_R12: assert property (@(posedge clk) disable iff (rst)
        snap |=> saved[0] == $past(run_adr) && saved[1] == $past(end_adr));

endmodule

// File: rtl/dma_chain_mover.sv
module dma_chain_mover #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          to_mem,
    input  logic          at_end,
    input  logic [AW-1:0] run_adr,
    input  logic          flush,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          advance,
    output logic          bus_fault,
    output logic          stg_empty
);

    logic          stg_valid;
    logic [DW-1:0] stg_data;

    assign dev_in_ready  = run && to_mem && !stg_valid && !at_end;
    assign mem_req       = run && (to_mem ? stg_valid : (!stg_valid && !at_end));
    assign mem_we        = to_mem;
    assign mem_addr      = run_adr;
    assign mem_wdata     = stg_data;
    assign dev_out_valid = !to_mem && stg_valid;
    assign dev_out_data  = stg_data;
    assign advance       = mem_req && mem_ack && !mem_err;
    assign bus_fault     = mem_req && mem_err;
    assign stg_empty     = !stg_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_data  <= '0;
        end else if (flush) begin
            stg_valid <= 1'b0;
        end else if (to_mem) begin
            if (dev_in_valid && dev_in_ready) begin
                stg_valid <= 1'b1;
                stg_data  <= dev_in_data;
            end else if (advance) begin
                stg_valid <= 1'b0;
            end
        end else begin
            if (advance) begin
                stg_valid <= 1'b1;
                stg_data  <= mem_rdata;
            end else if (dev_out_valid && dev_out_ready) begin
                stg_valid <= 1'b0;
            end
        end
    end

    assert_no_read_past_end_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> !at_end);

    assert_write_drains_R2: assert property (@(posedge clk) disable iff (rst)
        advance && mem_we |=> stg_empty);

    assert_flush_empties_R13: assert property (@(posedge clk) disable iff (rst)
        flush |=> stg_empty);

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          irq
);

    chan_flags_t        flags;
    csr_cmd_t           cmd;
    logic               csr_wr, to_mem, chain, halt, flush;
    logic               advance, bus_fault, stg_empty, at_end, buf_end;
    logic [AW-1:0]      run_adr, end_adr, q_base, q_end;
    logic [3:0][AW-1:0] saved;

    assign csr_wr  = reg_wr && (reg_addr == REG_CSR);
    assign cmd     = decode_cmd(reg_wdata);
    assign buf_end = flags.run && at_end && stg_empty;
    assign irq     = flags.done || flags.fault;

    dma_chain_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .cmd       (cmd),
        .buf_end   (buf_end),
        .bus_fault (bus_fault),
        .flags     (flags),
        .to_mem    (to_mem),
        .chain     (chain),
        .halt      (halt),
        .flush     (flush)
    );

    dma_chain_ptrs #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel_e'(reg_addr)),
        .wr_data (reg_wdata[AW-1:0]),
        .advance (advance),
        .chain   (chain),
        .snap    (halt),
        .run_adr (run_adr),
        .end_adr (end_adr),
        .q_base  (q_base),
        .q_end   (q_end),
        .saved   (saved),
        .at_end  (at_end)
    );

    dma_chain_mover #(.AW(AW), .DW(DW)) u_mover (
        .clk           (clk),
        .rst           (rst),
        .run           (flags.run),
        .to_mem        (to_mem),
        .at_end        (at_end),
        .run_adr       (run_adr),
        .flush         (flush),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .advance       (advance),
        .bus_fault     (bus_fault),
        .stg_empty     (stg_empty)
    );

    always_comb begin
        case (reg_addr)
            REG_CSR:      reg_rdata = flags_word(flags);
            REG_RUN_ADR:  reg_rdata = 32'(run_adr);
            REG_END_ADR:  reg_rdata = 32'(end_adr);
            REG_Q_BASE:   reg_rdata = 32'(q_base);
            REG_Q_END:    reg_rdata = 32'(q_end);
            REG_SV_RUN:   reg_rdata = 32'(saved[0]);
            REG_SV_END:   reg_rdata = 32'(saved[1]);
            REG_SV_QBASE: reg_rdata = 32'(saved[2]);
            REG_SV_QEND:  reg_rdata = 32'(saved[3]);
            default:      reg_rdata = '0;
        endcase
    end

    assert_clear_done_drops_irq_R10: assert property (@(posedge clk) disable iff (rst)
        csr_wr && cmd.clr_done && !flags.fault && !bus_fault |=> !irq);

    assert_fault_freezes_R6: assert property (@(posedge clk) disable iff (rst)
        bus_fault |=> !mem_req && run_adr == $past(run_adr));

endmodule

// File: tb/test_dma_chain_channel.sv
`timescale 1ns/100ps
module test_dma_chain_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_in_ready, dev_out_valid;
    logic [31:0] dev_in_data, dev_out_data;
    logic        mem_req, mem_we, mem_ack, mem_err, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] wr_mem [0:1023];
    int unsigned wr_count = 0;
    int unsigned src_cnt = 0;
    int unsigned sink_cnt = 0;
    logic [31:0] sink [0:31];

    always #2 clk = ~clk;

    assign dev_in_data = 32'hA500_0000 + src_cnt;
    assign mem_err     = mem_req && err_en && (mem_addr == err_addr);
    assign mem_ack     = mem_req && !mem_err;
    assign mem_rdata   = {16'hC0DE, mem_addr[15:0]};

    dma_chain_channel i_dma_chain_channel (
        .clk (clk), .rst (rst),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .dev_in_valid (1'b1), .dev_in_ready (dev_in_ready), .dev_in_data (dev_in_data),
        .dev_out_valid (dev_out_valid), .dev_out_ready (1'b1), .dev_out_data (dev_out_data),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .mem_ack (mem_ack), .mem_err (mem_err), .irq (irq)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) begin
            wr_mem[mem_addr[11:2]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (dev_in_ready) src_cnt <= src_cnt + 1;
        if (dev_out_valid) begin
            sink[sink_cnt[4:0]] <= dev_out_data;
            sink_cnt <= sink_cnt + 1;
        end
    end

    typedef struct packed {
        logic [3:0]  adr;
        logic [31:0] wdat;
        logic [31:0] expd;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1, 32'h0000_0100, 32'h0000_0100},  // R7 running address
        '{4'd1, 32'h0000_0104, 32'h0000_0100},  // R11 misaligned ignored
        '{4'd2, 32'h0000_0140, 32'h0000_0140},  // R7 end address
        '{4'd2, 32'h0000_0141, 32'h0000_0140},  // R11
        '{4'd3, 32'h0000_0208, 32'h0000_0000},  // R11 stays at reset value
        '{4'd3, 32'h0000_0200, 32'h0000_0200},  // R7 queued base
        '{4'd4, 32'h0000_0240, 32'h0000_0240},  // R7 queued end
        '{4'd4, 32'h0000_024F, 32'h0000_0240},  // R11
        '{4'd0, 32'h0002_0000, 32'h0200_0000},  // R8 set one-shot, R7 bit 25
        '{4'd0, 32'h0010_0000, 32'h0000_0000},  // R9 wipe
        '{4'd0, 32'h0012_0000, 32'h0200_0000},  // R8 set beats wipe
        '{4'd0, 32'h0010_0000, 32'h0000_0000}   // R9
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic wait_stop();
        logic [31:0] v;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            rd(4'd0, v);
            if (!v[24]) break;
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int unsigned base, sbase, wbase;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            rst = 1'b1;
        end
        rst = 1'b0;
        @(negedge clk);

        // reset state
        rd(4'd0, v); check("R7 reset csr", v, 32'h0);
        rd(4'd1, v); check("R7 reset running address", v, 32'h0);
        check("R10 reset irq", {31'b0, irq}, 32'h0);

        // register table
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].adr, VECS[i].wdat);
            rd(VECS[i].adr, v);
            check($sformatf("R7/R8/R9/R11 vector %0d", i), v, VECS[i].expd);
        end

        // one-shot device to memory (R1 R2 R4 R12)
        wr(4'd1, 32'h100);
        wr(4'd2, 32'h110);
        base = src_cnt; wbase = wr_count;
        wr(4'd0, 32'h0007_0000);
        wait_stop();
        for (int i = 0; i < 4; i++)
            check("R2 device word written", wr_mem[10'h40 + i], 32'hA500_0000 + base + i);
        check("R1 word count", wr_count - wbase, 32'd4);
        rd(4'd1, v); check("R1 running address at end", v, 32'h110);
        rd(4'd0, v); check("R4 done and one-shot, stopped", v, 32'h0A00_0000);
        check("R10 irq on done", {31'b0, irq}, 32'h1);
        rd(4'd5, v); check("R12 saved running", v, 32'h110);
        wr(4'd0, 32'h0008_0000);
        check("R10 clear done drops irq", {31'b0, irq}, 32'h0);
        rd(4'd0, v); check("R10 csr after clear", v, 32'h0200_0000);

        // chained memory to device (R2 R3 R5 R12)
        wr(4'd0, 32'h0010_0000);
        wr(4'd1, 32'h200);
        wr(4'd2, 32'h210);
        wr(4'd3, 32'h300);
        wr(4'd4, 32'h310);
        sbase = sink_cnt;
        wr(4'd0, 32'h0001_0000);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            rd(4'd1, v);
            if (v[11:8] == 4'h3) begin
                rd(4'd0, v);
                check("R3 chained, still running with done", v, 32'h0900_0000);
                break;
            end
        end
        wait_stop();
        check("R5 delivered word count", sink_cnt - sbase, 32'd8);
        for (int i = 0; i < 8; i++)
            check("R2/R3 delivered word", sink[(sbase + i) % 32],
                  {16'hC0DE, (i < 4) ? 16'(16'h200 + 4*i) : 16'(16'h300 + 4*(i-4))});
        rd(4'd0, v); check("R5 stopped instead of chaining", v, 32'h0800_0000);
        rd(4'd1, v); check("R5 running address", v, 32'h310);
        rd(4'd7, v); check("R12 saved queued base", v, 32'h300);

        // bus error device to memory (R6 R9 R12)
        wr(4'd0, 32'h0014_0000);
        wr(4'd1, 32'h400);
        wr(4'd2, 32'h440);
        err_addr = 32'h408; err_en = 1'b1;
        wbase = wr_count;
        wr(4'd0, 32'h0005_0000);
        wait_stop();
        rd(4'd0, v); check("R6 fault flag, stopped", v, 32'h1000_0000);
        check("R6 irq on fault", {31'b0, irq}, 32'h1);
        rd(4'd1, v); check("R6 running address frozen", v, 32'h408);
        rd(4'd5, v); check("R12 saved running at fault", v, 32'h408);
        check("R6 writes before fault", wr_count - wbase, 32'd2);
        check("R6 no request after fault", {31'b0, mem_req}, 32'h0);
        err_en = 1'b0;
        wr(4'd0, 32'h0014_0000);
        rd(4'd0, v); check("R9 wipe clears fault", v, 32'h0);
        check("R10 irq after wipe", {31'b0, irq}, 32'h0);

        // flush stranded word (R13)
        wr(4'd0, 32'h0024_0000);
        wr(4'd1, 32'h500);
        wr(4'd2, 32'h510);
        base = src_cnt;
        wr(4'd0, 32'h0007_0000);
        wait_stop();
        check("R13 first word is fresh", wr_mem[10'h140], 32'hA500_0000 + base);
        check("R13 last word", wr_mem[10'h143], 32'hA500_0000 + base + 3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule